// File: doc/BRIEF.md
# Memory Array Test Sequencer

This block walks an external static RAM through every location to find faulty storage. It sits on the command side of a simple synchronous RAM controller. For each access it raises a one-cycle request with a direction flag, an address and write data. It then allows the controller two more cycles, and samples the controller's unregistered read data on the third cycle of the access. Every access therefore takes exactly three cycles, which match the controller's idle, first and second cycles.

Four single-cycle start ticks select the modes:
- **Write sweep:** fills the whole array with a pattern derived from each address.
- **Read sweep:** reads every location back and counts mismatches.
- **Fault injection:** writes one deliberately wrong word at an address taken from an 8-bit switch value.
- **Interleaved sweep:** writes ascending addresses and, once far enough ahead, reads back the location written a fixed number of addresses earlier.

A mismatch counter and an injection counter are exposed for display.

Top module: `sram_tst_seq`

## Requirements
- R1: After reset `mem_o` is 0 and both `err_cnt_o` and `inj_cnt_o` are 0.
- R2: A write sweep issues exactly one write (`rw_o`=0) per address, ascending from 0 to 2^ADDR_W-1. The data is the bitwise inverse of the address, zero-extended or truncated to DATA_W bits.
- R3: Starting a write sweep sets `err_cnt_o` to 0 in the cycle after the start tick.
- R4: A read sweep issues one read (`rw_o`=1) per address, ascending. `rdata_i` is sampled two cycles after the request cycle, and `err_cnt_o` grows by one whenever it differs from the inverse of the address.
- R5: `err_cnt_o` saturates at 2^ERR_W-1 instead of wrapping.
- R6: A fault injection is one write to the switch value zero-extended to ADDR_W bits. The data is the address itself, which is the complement of the expected pattern. `inj_cnt_o` then increments by one.
- R7: An interleaved sweep writes address c. When c >= LAG, the next access reads address c-LAG and checks it as in R4. No read is issued for the first LAG writes.
- R8: Start ticks arriving while a mode is running are ignored.
- R9: When several ticks arrive together, the priority is write sweep, then read sweep, then injection, then interleaved sweep.
- R10: Each request on `mem_o` lasts one cycle, and requests within one run are exactly three cycles apart. No request appears after the run's final access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_tick_i | input | 1 | Start write sweep |
| rd_tick_i | input | 1 | Start read sweep |
| inj_tick_i | input | 1 | Start single fault injection |
| mix_tick_i | input | 1 | Start interleaved sweep |
| sw_i | input | SW_W | Injection address |
| mem_o | output | 1 | One-cycle access request to the controller |
| rw_o | output | 1 | 1 read, 0 write |
| addr_o | output | ADDR_W | Access address |
| wdata_o | output | DATA_W | Write data |
| rdata_i | input | DATA_W | Unregistered controller read data |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| inj_cnt_o | output | INJ_W | Number of injections |

## Verification
The hardest condition to reach is error-counter saturation, since it needs more mismatching locations than the counter can hold. The bench builds the sequencer with a narrow error counter and a small address space. Its memory model then flips a bit in the read data of a block of locations larger than the counter's range. Interleaved checking is driven by a model that stores a corrupted word at one address only during that sweep. Exactly one lagged read must then fail. Ticks are also injected in the middle of a sweep to show they have no effect.

// File: rtl/sram_tst_pkg.sv
package sram_tst_pkg;
  typedef enum logic [1:0] {MODE_WR, MODE_RD, MODE_INJ, MODE_MIX} mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_CYC1, ST_CYC2, ST_CYC3} st_e;
endpackage

// File: rtl/sram_tst_sat_cnt.sv
module sram_tst_sat_cnt #(
  parameter int W   = 16,
  parameter bit SAT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_nxt;

  generate
    if (SAT) begin : g_sat
      assign cnt_nxt = (cnt_q == '1) ? cnt_q : cnt_q + W'(1);
      // R5
      sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == '1 && !clr_i) |=> cnt_q == '1);
    end else begin : g_wrap
      assign cnt_nxt = cnt_q + W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R4
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/sram_tst_addr_gen.sv
module sram_tst_addr_gen
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int SW_W   = 8,
  parameter int LAG    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              sw_ld_i,
  input  logic [SW_W-1:0]   sw_i,
  input  mode_e             mode_i,
  input  logic              rd_op_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] exp_o,
  output logic              last_o,
  output logic              lag_ok_o
);
  localparam logic [ADDR_W-1:0] LAG_A = ADDR_W'(LAG);

  logic [ADDR_W-1:0] cnt_q, addr_mux;
  logic [SW_W-1:0]   sw_q;
  logic [DATA_W-1:0] addr_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sw_q  <= '0;
    end else begin
      if (clr_i)      cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + ADDR_W'(1);
      if (sw_ld_i)    sw_q  <= sw_i;
    end
  end

  always_comb begin
    if (mode_i == MODE_INJ)                addr_mux = ADDR_W'(sw_q);
    else if (mode_i == MODE_MIX && rd_op_i) addr_mux = cnt_q - LAG_A;
    else                                   addr_mux = cnt_q;
  end

  assign addr_ext = DATA_W'(addr_mux);
  assign exp_o    = ~addr_ext;
  assign wdata_o  = (mode_i == MODE_INJ) ? addr_ext : ~addr_ext;
  assign addr_o   = addr_mux;
  assign last_o   = (cnt_q == '1);
  assign lag_ok_o = (cnt_q >= LAG_A);

  // R7
  lag_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MIX && rd_op_i) |-> cnt_q >= LAG_A);
endmodule

// File: rtl/sram_tst_fsm.sv
module sram_tst_fsm
  import sram_tst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] start_i,  // [0] wr, [1] rd, [2] inj, [3] mix
  input  logic       last_i,
  input  logic       lag_ok_i,
  output mode_e      mode_o,
  output logic       rd_op_o,
  output logic       access_o,
  output logic       cnt_clr_o,
  output logic       cnt_inc_o,
  output logic       sw_ld_o,
  output logic       err_clr_o,
  output logic       err_chk_o,
  output logic       inj_inc_o
);
  st_e   st_q, st_d;
  mode_e mode_q, mode_d;
  logic  rd_q, rd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_WR;
      rd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      rd_q   <= rd_d;
    end
  end

  always_comb begin
    st_d      = st_q;
    mode_d    = mode_q;
    rd_d      = rd_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    sw_ld_o   = 1'b0;
    err_clr_o = 1'b0;
    inj_inc_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (|start_i) begin
        if (start_i[0])      mode_d = MODE_WR;
        else if (start_i[1]) mode_d = MODE_RD;
        else if (start_i[2]) mode_d = MODE_INJ;
        else                 mode_d = MODE_MIX;
        rd_d      = (mode_d == MODE_RD);
        cnt_clr_o = 1'b1;
        sw_ld_o   = 1'b1;
        err_clr_o = (mode_d == MODE_WR);
        st_d      = ST_CYC1;
      end
      ST_CYC1: st_d = ST_CYC2;
      ST_CYC2: st_d = ST_CYC3;
      ST_CYC3: begin
        unique case (mode_q)
          MODE_INJ: begin
            inj_inc_o = 1'b1;
            st_d      = ST_IDLE;
          end
          MODE_MIX: begin
            if (!rd_q && lag_ok_i) begin
              rd_d = 1'b1;
              st_d = ST_CYC1;
            end else begin
              rd_d = 1'b0;
              if (last_i) st_d = ST_IDLE;
              else begin
                cnt_inc_o = 1'b1;
                st_d      = ST_CYC1;
              end
            end
          end
          default: begin
            if (last_i) st_d = ST_IDLE;
            else begin
              cnt_inc_o = 1'b1;
              st_d      = ST_CYC1;
            end
          end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign mode_o    = mode_q;
  assign rd_op_o   = rd_q;
  assign access_o  = (st_q == ST_CYC1);
  assign err_chk_o = (st_q == ST_CYC3) && rd_q;

  // R10
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_o |=> !access_o);
  // R8
  busy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(mode_q));
  // R10
  access_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CYC1) |=> (st_q == ST_CYC2));
endmodule

// File: rtl/sram_tst_seq.sv
module sram_tst_seq
  import sram_tst_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int SW_W   = 8,
  parameter int ERR_W  = 16,
  parameter int INJ_W  = 8,
  parameter int LAG    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_tick_i,
  input  logic              rd_tick_i,
  input  logic              inj_tick_i,
  input  logic              mix_tick_i,
  input  logic [SW_W-1:0]   sw_i,
  output logic              mem_o,
  output logic              rw_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ERR_W-1:0]  err_cnt_o,
  output logic [INJ_W-1:0]  inj_cnt_o
);
  mode_e             mode;
  logic              rd_op, access, cnt_clr, cnt_inc, sw_ld;
  logic              err_clr, err_chk, inj_inc, last, lag_ok, mismatch;
  logic [DATA_W-1:0] exp_data;

  sram_tst_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i  ({mix_tick_i, inj_tick_i, rd_tick_i, wr_tick_i}),
    .last_i   (last),
    .lag_ok_i (lag_ok),
    .mode_o   (mode),
    .rd_op_o  (rd_op),
    .access_o (access),
    .cnt_clr_o(cnt_clr),
    .cnt_inc_o(cnt_inc),
    .sw_ld_o  (sw_ld),
    .err_clr_o(err_clr),
    .err_chk_o(err_chk),
    .inj_inc_o(inj_inc)
  );

  sram_tst_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SW_W(SW_W), .LAG(LAG)) u_agen (
    .clk_i, .rst_ni,
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .sw_ld_i (sw_ld),
    .sw_i    (sw_i),
    .mode_i  (mode),
    .rd_op_i (rd_op),
    .addr_o  (addr_o),
    .wdata_o (wdata_o),
    .exp_o   (exp_data),
    .last_o  (last),
    .lag_ok_o(lag_ok)
  );

  assign mismatch = err_chk && (rdata_i != exp_data);

  sram_tst_sat_cnt #(.W(ERR_W), .SAT(1'b1)) u_err (
    .clk_i, .rst_ni, .clr_i(err_clr), .inc_i(mismatch), .cnt_o(err_cnt_o)
  );

  sram_tst_sat_cnt #(.W(INJ_W), .SAT(1'b0)) u_inj (
    .clk_i, .rst_ni, .clr_i(1'b0), .inc_i(inj_inc), .cnt_o(inj_cnt_o)
  );

  assign mem_o = access;
  assign rw_o  = rd_op;

  // R6
  inj_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_o && mode == MODE_INJ) |-> !rw_o);
endmodule

// File: tb/sram_tst_seq_tb_top.sv
module sram_tst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 16, SWW = 8, EW = 6, IW = 8, LG = 16;
  localparam int N = 1 << AW;

  typedef struct {
    logic          rw;
    int            a;
    logic [DW-1:0] d;
    int            gap;
    string         req;
  } acc_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_t = 0, rd_t = 0, inj_t = 0, mix_t = 0;
  logic [SWW-1:0] sw = '0;
  logic mem, rw;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic [EW-1:0] err_cnt;
  logic [IW-1:0] inj_cnt;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  acc_t sb_q[$];

  // memory model: controller + RAM
  logic [DW-1:0] model_mem [N];
  logic [AW-1:0] lat_addr = '0;
  bit flip_en = 0;
  int flip_lim = 0;
  bit stuck_en = 0;
  logic [AW-1:0] stuck_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_tst_seq #(.ADDR_W(AW), .DATA_W(DW), .SW_W(SWW), .ERR_W(EW), .INJ_W(IW), .LAG(LG)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_tick_i(wr_t), .rd_tick_i(rd_t), .inj_tick_i(inj_t), .mix_tick_i(mix_t),
    .sw_i(sw), .mem_o(mem), .rw_o(rw), .addr_o(addr), .wdata_o(wdata),
    .rdata_i(rdata), .err_cnt_o(err_cnt), .inj_cnt_o(inj_cnt)
  );

  always @(posedge clk) begin
    if (mem) begin
      lat_addr <= addr;
      if (!rw) model_mem[addr] <= (stuck_en && addr == stuck_addr) ? wdata ^ DW'(1) : wdata;
    end
  end
  assign rdata = model_mem[lat_addr] ^ ((flip_en && int'(lat_addr) < flip_lim) ? DW'(1) : DW'(0));

  function automatic logic [DW-1:0] pat(input int a);
    return ~DW'(a);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic r, input int a, input logic [DW-1:0] d, input int gap, input string req);
    acc_t e;
    e.rw = r; e.a = a; e.d = d; e.gap = gap; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic tick(input logic [3:0] m);
    @(negedge clk);
    {mix_t, inj_t, rd_t, wr_t} = m;
    @(negedge clk);
    {mix_t, inj_t, rd_t, wr_t} = 4'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_sweep(input logic r, input string req);
    for (int a = 0; a < N; a++) push(r, a, pat(a), (a == 0) ? 0 : 3, req);
  endtask

  task automatic drained(input string req);
    check(sb_q.size() == 0, req, sb_q.size(), 0);
  endtask

  // monitor
  initial begin
    int cyc = 0, last = 0;
    acc_t e;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && mem) begin
        if (sb_q.size() == 0) check(1'b0, "R10 unexpected access addr", addr, -1);
        else begin
          e = sb_q.pop_front();
          check(rw == e.rw, {e.req, " direction"}, rw, e.rw);
          check(int'(addr) == e.a, {e.req, " address"}, addr, e.a);
          if (!e.rw) check(wdata == e.d, {e.req, " write data"}, wdata, e.d);
          if (e.gap != 0) check(cyc - last == e.gap, "R10 access spacing", cyc - last, e.gap);
          last = cyc;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1
    check(mem == 1'b0, "R1 mem_o after reset", mem, 0);
    check(err_cnt == 0, "R1 err after reset", err_cnt, 0);
    check(inj_cnt == 0, "R1 inj after reset", inj_cnt, 0);

    // R2 write sweep
    push_sweep(1'b0, "R2");
    tick(4'b0001);
    wait_cyc(3*N + 6);
    drained("R2 all writes seen");
    check(err_cnt == 0, "R2 err after write sweep", err_cnt, 0);

    // R4 clean read sweep
    push_sweep(1'b1, "R4");
    tick(4'b0010);
    wait_cyc(3*N + 6);
    drained("R4 all reads seen");
    check(err_cnt == 0, "R4 clean read err", err_cnt, 0);

    // R6 injection at 5
    sw = 8'd5;
    push(1'b0, 5, DW'(5), 0, "R6");
    tick(4'b0100);
    wait_cyc(8);
    drained("R6 single access");
    check(inj_cnt == 1, "R6 inj count", inj_cnt, 1);

    // R4 + R8: read detects one fault, mid-run ticks ignored
    push_sweep(1'b1, "R8 R4");
    tick(4'b0010);
    wait_cyc(30);
    tick(4'b0101);
    wait_cyc(3*N);
    drained("R8 no extra accesses");
    check(err_cnt == 1, "R4 one mismatch / R8 no clear", err_cnt, 1);
    check(inj_cnt == 1, "R8 inj unchanged", inj_cnt, 1);

    // R3 write sweep clears errors
    push_sweep(1'b0, "R3");
    tick(4'b0001);
    check(err_cnt == 0, "R3 err cleared at start", err_cnt, 0);
    wait_cyc(3*N + 6);
    drained("R3 writes seen");

    // R5 saturation
    flip_en = 1;
    flip_lim = 70;
    push_sweep(1'b1, "R5");
    tick(4'b0010);
    wait_cyc(3*N + 6);
    flip_en = 0;
    check(err_cnt == (1 << EW) - 1, "R5 saturated", err_cnt, (1 << EW) - 1);

    // R6 injection at top address
    sw = 8'hFF;
    push(1'b0, 255, DW'(255), 0, "R6");
    tick(4'b0100);
    wait_cyc(8);
    drained("R6 second injection");
    check(inj_cnt == 2, "R6 inj count 2", inj_cnt, 2);

    // R9 read beats inject
    push_sweep(1'b1, "R9 read over inject");
    tick(4'b0110);
    wait_cyc(3*N + 6);
    drained("R9 read sweep");
    check(inj_cnt == 2, "R9 no injection", inj_cnt, 2);
    check(err_cnt == (1 << EW) - 1, "R5 stays saturated", err_cnt, (1 << EW) - 1);

    // R9 write beats mix
    push_sweep(1'b0, "R9 write over mix");
    tick(4'b1001);
    wait_cyc(3*N + 6);
    drained("R9 write sweep");
    check(err_cnt == 0, "R9 write sweep cleared", err_cnt, 0);

    // R7 interleaved with one stuck location
    stuck_en = 1;
    stuck_addr = 8'd40;
    for (int c = 0; c < N; c++) begin
      push(1'b0, c, pat(c), (c == 0) ? 0 : 3, "R7 write");
      if (c >= LG) push(1'b1, c - LG, '0, 3, "R7 lagged read");
    end
    tick(4'b1000);
    wait_cyc(3*(2*N - LG) + 6);
    stuck_en = 0;
    drained("R7 all accesses seen");
    check(err_cnt == 1, "R7 one lagged mismatch", err_cnt, 1);

    // R10 idle after run
    wait_cyc(20);
    drained("R10 quiet after run");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule